// File: doc/BRIEF.md
# Serial Audio Buffer Core with Debug Freeze

This block sits between a serial audio port and a 16-bit register bus and holds audio words in two queues. Words from the receive shift path enter a receive queue, and software drains that queue by reading a data register. Software fills a transmit queue by writing a second data register. Each time the frame logic asks for the next outgoing word, the oldest transmit entry moves into the transmit shift register. Two status registers report the fill level of each queue, together with a sticky error bit that software clears by writing 1 to it.

A debug freeze input lets an external development tool inspect the block without changing it. While freeze is active, the queues, the transmit shift register and all status bits hold their values. Bus reads still return data, and bus writes are ignored. The freeze input comes from another clock domain, so it passes through a two-flop synchronizer before it takes effect. Any serial event that arrives while the block is frozen is dropped and is not replayed later.

Top module: `aud_buf_core`

## Requirements
- R1: After a synchronous reset, `bus_rdata` and `tx_shift` are 0, both queues are empty, and both sticky error bits are clear.
- R2: When `rx_valid` is high, `rx_word` is appended to the receive queue, which holds 8 entries. A bus read at byte offset 0x00 returns the oldest entry on `bus_rdata` one cycle later and removes it. A read at 0x00 while the queue is empty returns 0.
- R3: A read at 0x18 returns the receive status with these bits: bit0 = empty, bit1 = full (8 entries), bit2 = almost full (6 or more entries), bit3 = overrun. All other bits read 0, and so do unmapped offsets.
- R4: A receive word that arrives while the queue held 8 entries at the start of the cycle is dropped and sets the overrun bit. The drop happens even if a read pops an entry in the same cycle. Writing 1 to bit3 at 0x18 clears the overrun bit. If a set and a clear fall in the same cycle, the set wins.
- R5: A bus write at 0x0A appends to the transmit queue (8 entries). A write to a full queue is discarded. A read at 0x1A returns the transmit status: bit0 = empty, bit1 = full, bit2 = almost empty (2 or fewer entries), bit3 = underrun.
- R6: A `tx_load` pulse moves the oldest transmit entry into `tx_shift` at the next edge. If the queue was empty at the start of the cycle, `tx_shift` becomes 0 and the underrun bit is set, and a write in the same cycle is still stored. Writing 1 to bit3 at 0x1A clears the underrun bit, and a set wins over a clear.
- R7: `freeze_in` takes effect from the second rising edge after it changes: two synchronizer stages.
- R8: While frozen, received words are not stored. A read at 0x00 returns the head entry without removing it. The receive status bits do not change, and a write of 1 to bit3 at 0x18 has no effect.
- R9: While frozen, transmit writes are discarded, `tx_load` leaves `tx_shift` unchanged, the transmit status bits do not change, and a write of 1 to bit3 at 0x1A has no effect.
- R10: After freeze is released, operation resumes on the next synchronized cycle. Events that arrived during freeze are lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| freeze_in | input | 1 | Asynchronous debug freeze request |
| bus_addr | input | 8 | Register byte offset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| rx_valid | input | 1 | Received word strobe |
| rx_word | input | 16 | Received word |
| tx_load | input | 1 | Request for the next outgoing word |
| tx_shift | output | 16 | Transmit shift register contents |

## Verification
Two functions on the same queue can fall in one cycle. On the receive side, a serial push can coincide with a bus pop. On the transmit side, a bus write can coincide with a shift load. The bench drives these coincidences deliberately at both ends of the queue: a push together with a pop on a full queue, and a write together with a load on an empty queue. It also drives them randomly, with freeze toggling through the activity. A behavioural queue model decides every case from the state at the start of the cycle, and the bench compares `bus_rdata` and `tx_shift` against that model after every edge.

// File: rtl/aud_buf_pkg.sv
package aud_buf_pkg;
  localparam int OFS_W = 8;
  localparam logic [OFS_W-1:0] OFS_RX_DATA = 8'h00;
  localparam logic [OFS_W-1:0] OFS_TX_DATA = 8'h0A;
  localparam logic [OFS_W-1:0] OFS_RX_STAT = 8'h18;
  localparam logic [OFS_W-1:0] OFS_TX_STAT = 8'h1A;
  localparam int BIT_EMPTY = 0;
  localparam int BIT_FULL  = 1;
  localparam int BIT_LEVEL = 2;
  localparam int BIT_ERR   = 3;
endpackage

// File: rtl/aud_buf_sync.sv
module aud_buf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d_async;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d_async};
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/aud_buf_fifo.sv
module aud_buf_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic [DW-1:0]                wdata,
  input  logic                         pop,
  output logic [DW-1:0]                head,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH-1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  assign push_ok = push && (count != FULL_CNT);
  assign pop_ok  = pop  && (count != '0);

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head = mem[rd_ptr];

  // R2: the queue never holds more than its depth
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_CNT);

  // R2: a refused push leaves the count unchanged when no pop happens
  p_full_holds_r2: assert property (@(posedge clk) disable iff (rst)
    (count == FULL_CNT && !pop) |=> count == FULL_CNT);
endmodule

// File: rtl/aud_buf_core.sv
module aud_buf_core
  import aud_buf_pkg::*;
#(
  parameter int DW      = 16,
  parameter int DEPTH   = 8,
  parameter int AF_LVL  = 6,
  parameter int AE_LVL  = 2,
  parameter int SYNC_N  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             freeze_in,
  input  logic [OFS_W-1:0] bus_addr,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic             rx_valid,
  input  logic [DW-1:0]    rx_word,
  input  logic             tx_load,
  output logic [DW-1:0]    tx_shift
);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] AF_CNT   = CW'(AF_LVL);
  localparam logic [CW-1:0] AE_CNT   = CW'(AE_LVL);

  logic          frz;
  logic [CW-1:0] rx_cnt, tx_cnt;
  logic [DW-1:0] rx_head, tx_head;
  logic          rx_ovf, tx_unf;
  logic          rx_empty, rx_full, rx_af, tx_empty, tx_full, tx_ae;
  logic          rd_rxd, wr_txd, wr_rxs, wr_txs;
  logic          rx_push, rx_pop, tx_push, tx_pop;
  logic          ovf_set, unf_set;
  logic [DW-1:0] rx_stat, tx_stat, rd_mux;

  aud_buf_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .d_async(freeze_in), .q_sync(frz)
  );

  assign rd_rxd = bus_rd && (bus_addr == OFS_RX_DATA);
  assign wr_txd = bus_wr && (bus_addr == OFS_TX_DATA);
  assign wr_rxs = bus_wr && (bus_addr == OFS_RX_STAT);
  assign wr_txs = bus_wr && (bus_addr == OFS_TX_STAT);

  assign rx_push = rx_valid && !frz;
  assign rx_pop  = rd_rxd   && !frz;
  assign tx_push = wr_txd   && !frz;
  assign tx_pop  = tx_load  && !frz;

  aud_buf_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .push(rx_push), .wdata(rx_word),
    .pop(rx_pop), .head(rx_head), .count(rx_cnt)
  );

  aud_buf_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .push(tx_push), .wdata(bus_wdata),
    .pop(tx_pop), .head(tx_head), .count(tx_cnt)
  );

  assign rx_empty = (rx_cnt == '0);
  assign rx_full  = (rx_cnt == FULL_CNT);
  assign rx_af    = (rx_cnt >= AF_CNT);
  assign tx_empty = (tx_cnt == '0);
  assign tx_full  = (tx_cnt == FULL_CNT);
  assign tx_ae    = (tx_cnt <= AE_CNT);

  assign ovf_set = rx_push && rx_full;
  assign unf_set = tx_pop && tx_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_ovf <= 1'b0;
      tx_unf <= 1'b0;
    end else begin
      if (ovf_set)                              rx_ovf <= 1'b1;
      else if (wr_rxs && !frz && bus_wdata[BIT_ERR]) rx_ovf <= 1'b0;
      if (unf_set)                              tx_unf <= 1'b1;
      else if (wr_txs && !frz && bus_wdata[BIT_ERR]) tx_unf <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         tx_shift <= '0;
    else if (tx_pop) tx_shift <= tx_empty ? '0 : tx_head;
  end

  always_comb begin
    rx_stat = '0;
    rx_stat[BIT_EMPTY] = rx_empty;
    rx_stat[BIT_FULL]  = rx_full;
    rx_stat[BIT_LEVEL] = rx_af;
    rx_stat[BIT_ERR]   = rx_ovf;
    tx_stat = '0;
    tx_stat[BIT_EMPTY] = tx_empty;
    tx_stat[BIT_FULL]  = tx_full;
    tx_stat[BIT_LEVEL] = tx_ae;
    tx_stat[BIT_ERR]   = tx_unf;
    case (bus_addr)
      OFS_RX_DATA: rd_mux = rx_empty ? '0 : rx_head;
      OFS_RX_STAT: rd_mux = rx_stat;
      OFS_TX_STAT: rd_mux = tx_stat;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // R8: frozen state keeps the receive level and overrun bit
  p_frz_rx_hold_r8: assert property (@(posedge clk) disable iff (rst)
    frz |=> ($stable(rx_cnt) && $stable(rx_ovf)));

  // R9: frozen state keeps the transmit level, underrun bit and shift word
  p_frz_tx_hold_r9: assert property (@(posedge clk) disable iff (rst)
    frz |=> ($stable(tx_cnt) && $stable(tx_unf) && $stable(tx_shift)));

  // R4: a word arriving at a full queue raises overrun
  p_overrun_r4: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !frz && rx_cnt == FULL_CNT) |=> rx_ovf);

  // R6: a load from an empty queue sends zero and raises underrun
  p_underrun_r6: assert property (@(posedge clk) disable iff (rst)
    (tx_load && !frz && tx_cnt == '0) |=> (tx_shift == '0 && tx_unf));

  // R6: tx_shift only moves on an unfrozen load
  p_shift_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !(tx_load && !frz) |=> $stable(tx_shift));
endmodule

// File: tb/aud_buf_core_bench.sv
`timescale 1ns/1ps
module aud_buf_core_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        freeze_in;
  logic [7:0]  bus_addr;
  logic        bus_rd, bus_wr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        rx_valid;
  logic [15:0] rx_word;
  logic        tx_load;
  logic [15:0] tx_shift;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  aud_buf_core u_aud_buf_core (
    .clk(clk), .rst(rst), .freeze_in(freeze_in), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_word(rx_word),
    .tx_load(tx_load), .tx_shift(tx_shift)
  );

  // behavioural reference model
  logic [15:0] rxq[$];
  logic [15:0] txq[$];
  logic        m_rxo, m_txu, m_f1, m_f2, fz, set_o, set_u;
  logic [15:0] m_rdata, m_txs;
  int          pre_rx, pre_tx;

  always @(posedge clk) begin
    fz = m_f2;
    m_f2 = m_f1;
    m_f1 = freeze_in;
    if (rst) begin
      rxq.delete(); txq.delete();
      m_rxo = 0; m_txu = 0; m_rdata = 0; m_txs = 0; m_f1 = 0; m_f2 = 0;
    end else begin
      pre_rx = rxq.size();
      pre_tx = txq.size();
      set_o = 0; set_u = 0;
      if (bus_rd) begin
        case (bus_addr)
          8'h00:   m_rdata = (pre_rx > 0) ? rxq[0] : 16'h0;
          8'h18:   m_rdata = {12'h0, m_rxo, pre_rx >= 6, pre_rx == 8, pre_rx == 0};
          8'h1A:   m_rdata = {12'h0, m_txu, pre_tx <= 2, pre_tx == 8, pre_tx == 0};
          default: m_rdata = 16'h0;
        endcase
      end
      if (!fz) begin
        if (bus_rd && bus_addr == 8'h00 && pre_rx > 0) void'(rxq.pop_front());
        if (rx_valid) begin
          if (pre_rx < 8) rxq.push_back(rx_word);
          else set_o = 1;
        end
        if (bus_wr && bus_addr == 8'h0A && pre_tx < 8) txq.push_back(bus_wdata);
        if (tx_load) begin
          if (pre_tx > 0) m_txs = txq.pop_front();
          else begin m_txs = 0; set_u = 1; end
        end
        if (set_o) m_rxo = 1;
        else if (bus_wr && bus_addr == 8'h18 && bus_wdata[3]) m_rxo = 0;
        if (set_u) m_txu = 1;
        else if (bus_wr && bus_addr == 8'h1A && bus_wdata[3]) m_txu = 0;
      end
    end
  end

  task automatic compare();
    checks++;
    if (bus_rdata !== m_rdata) begin
      errors++;
      $display("FAIL %s bus_rdata actual %h expected %h at %0t", cur_req, bus_rdata, m_rdata, $time);
    end
    checks++;
    if (tx_shift !== m_txs) begin
      errors++;
      $display("FAIL %s tx_shift actual %h expected %h at %0t", cur_req, tx_shift, m_txs, $time);
    end
  endtask

  task automatic step(input logic rd, input logic wr, input logic [7:0] a,
                      input logic [15:0] wd, input logic rv, input logic [15:0] rw,
                      input logic tl);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    rx_valid = rv; rx_word = rw; tx_load = tl;
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 8'h00, 16'h0, 0, 16'h0, 0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; freeze_in = 0;
    bus_rd = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    rx_valid = 0; rx_word = 0; tx_load = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    cur_req = "R1";
    compare();
    step(1, 0, 8'h18, 0, 0, 0, 0);
    step(1, 0, 8'h1A, 0, 0, 0, 0);

    // R2 receive path and ordering
    cur_req = "R2";
    for (int i = 0; i < 3; i++) step(0, 0, 8'h00, 0, 1, 16'h1100 + 16'(i), 0);
    for (int i = 0; i < 4; i++) step(1, 0, 8'h00, 0, 0, 0, 0);

    // R3 level bits at several fills
    cur_req = "R3";
    for (int i = 0; i < 8; i++) begin
      step(0, 0, 8'h00, 0, 1, 16'h2200 + 16'(i), 0);
      step(1, 0, 8'h18, 0, 0, 0, 0);
    end
    step(1, 0, 8'h04, 0, 0, 0, 0);

    // R4 overrun, push with pop at full, clear
    cur_req = "R4";
    step(0, 0, 8'h00, 0, 1, 16'hDEAD, 0);
    step(1, 0, 8'h18, 0, 0, 0, 0);
    step(1, 0, 8'h00, 0, 1, 16'hBEEF, 0);
    step(1, 0, 8'h18, 0, 0, 0, 0);
    step(0, 1, 8'h18, 16'h0008, 1, 16'h3333, 0);
    step(1, 0, 8'h18, 0, 0, 0, 0);
    step(1, 1, 8'h18, 16'h0008, 0, 0, 0);
    step(1, 0, 8'h18, 0, 0, 0, 0);
    for (int i = 0; i < 9; i++) step(1, 0, 8'h00, 0, 0, 0, 0);

    // R5 transmit writes and status
    cur_req = "R5";
    for (int i = 0; i < 9; i++) begin
      step(0, 1, 8'h0A, 16'h4400 + 16'(i), 0, 0, 0);
      step(1, 0, 8'h1A, 0, 0, 0, 0);
    end

    // R6 loads, underrun, write+load at empty
    cur_req = "R6";
    for (int i = 0; i < 9; i++) step(1, 0, 8'h1A, 0, 0, 0, 1);
    step(1, 1, 8'h0A, 16'h5555, 0, 0, 1);
    step(1, 0, 8'h1A, 0, 0, 0, 1);
    step(0, 1, 8'h1A, 16'h0008, 0, 0, 0);
    step(1, 0, 8'h1A, 0, 0, 0, 0);

    // R7 synchronizer latency, R8/R9 frozen behaviour
    step(0, 0, 8'h00, 0, 1, 16'h6001, 0);
    step(0, 0, 8'h00, 0, 1, 16'h6002, 0);
    step(0, 1, 8'h0A, 16'h7001, 0, 0, 0);
    step(0, 1, 8'h0A, 16'h7002, 0, 0, 0);
    step(0, 0, 8'h00, 0, 0, 0, 1);
    cur_req = "R7";
    freeze_in = 1;
    step(0, 0, 8'h00, 0, 1, 16'h6003, 0);
    step(0, 0, 8'h00, 0, 1, 16'h6004, 0);
    cur_req = "R8";
    step(1, 0, 8'h00, 0, 1, 16'h6005, 0);
    step(1, 0, 8'h00, 0, 0, 0, 0);
    step(1, 0, 8'h18, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) step(0, 0, 8'h00, 0, 1, 16'h6100, 0);
    step(0, 1, 8'h18, 16'h0008, 0, 0, 0);
    step(1, 0, 8'h18, 0, 0, 0, 0);
    cur_req = "R9";
    step(0, 1, 8'h0A, 16'h7003, 0, 0, 1);
    step(0, 0, 8'h00, 0, 0, 0, 1);
    step(1, 0, 8'h1A, 0, 0, 0, 0);
    step(0, 1, 8'h1A, 16'h0008, 0, 0, 0);
    step(1, 0, 8'h1A, 0, 0, 0, 0);

    // R10 release, lost events, resumed operation
    cur_req = "R10";
    freeze_in = 0;
    step(0, 0, 8'h00, 0, 1, 16'h6200, 1);
    step(1, 0, 8'h00, 0, 1, 16'h6201, 1);
    for (int i = 0; i < 4; i++) step(1, 0, 8'h00, 0, 0, 0, 1);
    step(1, 0, 8'h18, 0, 0, 0, 0);
    step(1, 0, 8'h1A, 0, 0, 0, 0);

    // mixed random traffic with freeze toggling
    cur_req = "R2";
    for (int i = 0; i < 1500; i++) begin
      logic [7:0] a;
      case ($urandom_range(0, 4))
        0: a = 8'h00;
        1: a = 8'h0A;
        2: a = 8'h18;
        3: a = 8'h1A;
        default: a = 8'h06;
      endcase
      if ($urandom_range(0, 40) == 0) freeze_in = ~freeze_in;
      step($urandom_range(0, 1) == 1, $urandom_range(0, 2) == 0, a,
           16'($urandom), $urandom_range(0, 2) != 0, 16'($urandom),
           $urandom_range(0, 1) == 1);
    end
    freeze_in = 0;
    idle(4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule